// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

This block is one 16-bit timer channel that produces a pulse-width-modulated waveform on a single output pin. Two compare values shape the waveform. The period compare marks the end of each cycle. At that point the counter restarts at FFFCh and the pin takes a programmed level. The pulse compare marks an edge inside the cycle, where the pin takes a second programmed level. The counter advances only on ticks from a selectable source: the system clock divided by 1, 2 or 4, or an external tick input.

Software writes three locations through a simple write port. The first two hold the pulse compare and the period compare, and the third holds the control bits. Compare writes go to buffer registers. The values in use are refreshed from the buffers only when a period ends, or when PWM mode is switched on. A period that is already running therefore never sees a half-updated pair of values, and the pin never glitches.

Top module: `pwm_dual_cmp_timer`

## Requirements
- R1: After reset the counter reads FFFCh, the output pin is 0, and every buffer, active compare value and control bit is 0.
- R2: A write with wr_en high goes to the location at wr_addr: 0 is the pulse compare buffer, 1 is the period compare buffer, and 2 is control. Control bits: bit0 = pulse-match level, bit1 = period-match level, bit2 = output enable, bit3 = PWM enable, bits 5:4 = tick select. Address 3 is ignored.
- R3: Tick select 0 ticks every clock. Select 1 ticks every second clock and select 2 every fourth, counted from the cycle after PWM was enabled. Select 3 ticks on each clock where ext_tick is high.
- R4: While running, each tick adds one to the counter, and the counter wraps from FFFFh to 0000h. Without a tick the counter holds.
- R5: A tick that finds the counter equal to the active period compare reloads the counter to FFFCh and sets the pin level to the period-match level.
- R6: A tick that finds the counter equal to the active pulse compare, and not equal to the period compare, sets the pin level to the pulse-match level. The counter still increments.
- R7: When both compares match on the same tick, the period compare wins for both the level and the reload.
- R8: Compare writes reach the active compares only on a period match or on the first cycle of PWM enable. On a period match the buffer contents from before that cycle's write are used.
- R9: With PWM disabled, the counter holds FFFCh, the prescaler is cleared, and the pin level is the inverse of the period-match level. On enable, one load cycle copies the buffers and holds the counter before counting starts.
- R10: With output enable clear, the pin is 0 one cycle later, whatever the level.
- R11: pwm_o is registered. It shows the level decided in a cycle on the following cycle, together with the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| ext_tick | input | 1 | External tick, used when tick select is 3 |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM output pin |

## Verification
The pulse match and the period match can land on the same tick, and a period match can also coincide with a buffer write. The bench forces both cases on purpose. It loads equal pulse and period values, and it writes new compare values on the exact cycle the counter reaches the period. A cycle-level reference model built from the requirements then decides which level the pin must take and which buffer contents must become active. Random traffic adds more such collisions, using small compare values close to the FFFCh restart point.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PULSE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  typedef enum logic [1:0] {
    TK_DIV1 = 2'd0,
    TK_DIV2 = 2'd1,
    TK_DIV4 = 2'd2,
    TK_EXT  = 2'd3
  } tick_sel_e;

  // packed MSB first: bits 5:4 select, 3 pwm, 2 oe, 1 period level, 0 pulse level
  typedef struct packed {
    tick_sel_e tsel;
    logic      pwm_en;
    logic      out_en;
    logic      lvl_period;
    logic      lvl_pulse;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned PRE_W = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run_en,
  input  tick_sel_e sel,
  input  logic      ext_tick,
  output logic      tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run_en) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      TK_DIV1: tick = run_en;
      TK_DIV2: tick = run_en & pre_q[0];
      TK_DIV4: tick = run_en & (&pre_q[1:0]);
      default: tick = run_en & ext_tick;
    endcase
  end

  // R3: divide-by-4 never ticks on two adjacent cycles
  a_r3_div4_spacing: assert property (@(posedge clk) disable iff (rst)
    (run_en && sel == TK_DIV4 && tick) |=> !(tick && sel == TK_DIV4));
  // R9: prescaler cleared while disabled
  a_r9_pre_clear: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> pre_q == '0);
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_pulse,
  input  logic         wr_period,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] act_pulse,
  output logic [W-1:0] act_period
);
  logic [W-1:0] buf_pulse_q, buf_period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_pulse_q  <= '0;
      buf_period_q <= '0;
    end else begin
      if (wr_pulse)  buf_pulse_q  <= wr_data;
      if (wr_period) buf_period_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pulse  <= '0;
      act_period <= '0;
    end else if (load) begin
      act_pulse  <= buf_pulse_q;
      act_period <= buf_period_q;
    end
  end

  // R8: active compares change only on a load
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_pulse) && $stable(act_period)));
endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core #(
  parameter int unsigned W      = 16,
  parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] act_pulse,
  input  logic [W-1:0] act_period,
  input  logic         lvl_pulse,
  input  logic         lvl_period,
  input  logic         out_en,
  output logic         load,
  output logic [W-1:0] count,
  output logic         pwm_out
);
  logic run_q, lvl_q;
  logic start, active, hit_per, hit_pul;
  logic [W-1:0] cnt_d;
  logic lvl_d;

  assign start   = en & ~run_q;
  assign active  = en & run_q;
  assign hit_per = active & tick & (count == act_period);
  assign hit_pul = active & tick & (count == act_pulse);
  assign load    = start | hit_per;

  always_comb begin
    cnt_d = count;
    lvl_d = lvl_q;
    if (!en || start) begin
      cnt_d = RELOAD;
      lvl_d = ~lvl_period;
    end else if (hit_per) begin
      cnt_d = RELOAD;
      lvl_d = lvl_period;
    end else if (active && tick) begin
      cnt_d = count + 1'b1;
      if (hit_pul) lvl_d = lvl_pulse;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      count   <= RELOAD;
      lvl_q   <= 1'b1;
      pwm_out <= 1'b0;
    end else begin
      run_q   <= en;
      count   <= cnt_d;
      lvl_q   <= lvl_d;
      pwm_out <= out_en & lvl_d;
    end
  end

  // R5: period match reloads
  a_r5_period_reload: assert property (@(posedge clk) disable iff (rst)
    (active && tick && count == act_period) |=> count == RELOAD);
  // R9: disabled counter holds at reload value
  a_r9_hold_reload: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == RELOAD);
  // R4: no tick, no movement
  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !tick) |=> $stable(count));
  // R10: output disabled drives low
  a_r10_out_off: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pwm_out);
  // R6: lone pulse match takes pulse level
  a_r6_pulse_level: assert property (@(posedge clk) disable iff (rst)
    (active && tick && count == act_pulse && count != act_period)
      |=> lvl_q == $past(lvl_pulse));
  // R7: coincident matches take period level
  a_r7_period_wins: assert property (@(posedge clk) disable iff (rst)
    (active && tick && count == act_pulse && count == act_period)
      |=> (lvl_q == $past(lvl_period) && count == RELOAD));
endmodule

// File: rtl/pwm_dual_cmp_timer.sv
module pwm_dual_cmp_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned  CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_tick,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_o
);
  ctrl_t ctrl_q;
  logic wr_pulse, wr_period, wr_ctrl;
  logic tick, load;
  logic [CNT_W-1:0] act_pulse, act_period;

  assign wr_pulse  = wr_en && (wr_addr == A_PULSE);
  assign wr_period = wr_en && (wr_addr == A_PERIOD);
  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  pwm_tick_gen #(.PRE_W(2)) u_tick (
    .clk(clk), .rst(rst), .run_en(ctrl_q.pwm_en), .sel(ctrl_q.tsel),
    .ext_tick(ext_tick), .tick(tick)
  );

  pwm_cmp_bank #(.W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_period(wr_period),
    .wr_data(wr_data), .load(load),
    .act_pulse(act_pulse), .act_period(act_period)
  );

  pwm_cnt_core #(.W(CNT_W), .RELOAD(RELOAD)) u_core (
    .clk(clk), .rst(rst), .en(ctrl_q.pwm_en), .tick(tick),
    .act_pulse(act_pulse), .act_period(act_period),
    .lvl_pulse(ctrl_q.lvl_pulse), .lvl_period(ctrl_q.lvl_period),
    .out_en(ctrl_q.out_en), .load(load), .count(count_o), .pwm_out(pwm_o)
  );

  // R2: address 3 leaves control untouched
  a_r2_addr3_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_pwm_dual_cmp_timer.sv
module tb_pwm_dual_cmp_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic ext_tick = 1'b0;
  logic [15:0] count_o;
  logic pwm_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pwm_dual_cmp_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_tick(ext_tick), .count_o(count_o), .pwm_o(pwm_o));

  // reference model state
  logic [5:0]  m_ctrl;
  logic [15:0] m_bp, m_bq, m_ap, m_aq, m_cnt;
  logic [1:0]  m_pre;
  logic m_run, m_lvl, m_out;

  function automatic logic m_tick(logic [5:0] c, logic [1:0] p, logic e);
    if (!c[3]) return 1'b0;
    case (c[5:4])
      2'd0: return 1'b1;
      2'd1: return p[0];
      2'd2: return p == 2'd3;
      default: return e;
    endcase
  endfunction

  always @(posedge clk) begin
    logic tk, st, act, hp, hq;
    logic [15:0] nc; logic nl;
    cyc++;
    if (rst) begin
      m_ctrl = '0; m_bp = '0; m_bq = '0; m_ap = '0; m_aq = '0;
      m_cnt = 16'hFFFC; m_pre = '0; m_run = 0; m_lvl = 1; m_out = 0;
    end else begin
      tk = m_tick(m_ctrl, m_pre, ext_tick);
      st = m_ctrl[3] & ~m_run; act = m_ctrl[3] & m_run;
      hq = act & tk & (m_cnt == m_aq);
      hp = act & tk & (m_cnt == m_ap);
      nc = m_cnt; nl = m_lvl;
      if (!m_ctrl[3] || st) begin nc = 16'hFFFC; nl = ~m_ctrl[1]; end
      else if (hq) begin nc = 16'hFFFC; nl = m_ctrl[1]; end
      else if (act && tk) begin nc = m_cnt + 1; if (hp) nl = m_ctrl[0]; end
      if (st || hq) begin m_ap = m_bp; m_aq = m_bq; end
      m_out = m_ctrl[2] & nl;
      m_cnt = nc; m_lvl = nl; m_run = m_ctrl[3];
      m_pre = m_ctrl[3] ? m_pre + 1 : 2'd0;
      if (wr_en && wr_addr == 2'd0) m_bp = wr_data;
      if (wr_en && wr_addr == 2'd1) m_bq = wr_data;
      if (wr_en && wr_addr == 2'd2) m_ctrl = wr_data[5:0];
    end
  end

  task automatic check(string t, logic [15:0] act_v, logic [15:0] exp_v, string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h cycle=%0d", t, what, act_v, exp_v, cyc);
    end
  endtask

  // compare every cycle after the edge
  always @(negedge clk) if (!rst && !done) begin
    check(tag, count_o, m_cnt, "count");
    check(tag, {15'd0, pwm_o}, {15'd0, m_out}, "pwm");
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", count_o, 16'hFFFC, "reset count");
    check("R1", {15'd0, pwm_o}, 16'd0, "reset pwm");
    // R2, R5, R6, R11: basic waveform, pulse at 2, period at 6
    tag = "R2";
    wr(2'd0, 16'd2); wr(2'd1, 16'd6);
    wr(2'd3, 16'h003F);
    check("R2", {15'd0, pwm_o}, 16'd0, "addr3 write ignored");
    tag = "R5"; wr(2'd2, 16'h000E); idle(40);
    tag = "R6"; wr(2'd2, 16'h000D); idle(40);
    // R4: wrap FFFF->0000 with period 3
    tag = "R4"; wr(2'd1, 16'd3); idle(30);
    // R7: equal compares
    tag = "R7"; wr(2'd0, 16'd1); wr(2'd1, 16'd1); idle(30);
    wr(2'd0, 16'hFFFE); wr(2'd1, 16'hFFFE); idle(20);
    // R8: buffer write mid-period, then write on the match cycle
    tag = "R8"; wr(2'd1, 16'd20); idle(5); wr(2'd0, 16'd9); idle(40);
    // R3: each tick select
    tag = "R3"; wr(2'd2, 16'h001E); idle(80);
    wr(2'd2, 16'h002E); idle(120);
    wr(2'd2, 16'h003E);
    for (int i = 0; i < 200; i++) begin @(negedge clk); ext_tick = ($urandom % 3) == 0; end
    // R9: disable and re-enable
    tag = "R9"; wr(2'd2, 16'h0006); idle(5);
    check("R9", count_o, 16'hFFFC, "disabled count");
    check("R9", {15'd0, pwm_o}, 16'd0, "disabled pwm is ~lvl_period");
    wr(2'd2, 16'h000E); idle(30);
    // R10: output enable off
    tag = "R10"; wr(2'd2, 16'h000B); idle(2);
    check("R10", {15'd0, pwm_o}, 16'd0, "oe clear");
    idle(20);
    // random traffic
    tag = "R11";
    void'($urandom(32'h5EED));
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      ext_tick = $urandom % 2;
      wr_en = ($urandom % 16) == 0;
      wr_addr = $urandom % 4;
      case ($urandom % 4)
        0: wr_data = $urandom % 24;
        1: wr_data = 16'hFFFC + ($urandom % 4);
        2: wr_data = 16'h0008 | ($urandom % 64);
        default: wr_data = $urandom % 12;
      endcase
    end
    @(negedge clk); wr_en = 0;
    idle(5);
    finish_run();
  end
endmodule